// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, in a single cycle, which of sixteen receive message buffers accept an incoming CAN frame identifier. Each buffer holds a programmed identifier, a flag that says whether it expects a standard or an extended frame, and an enable bit. Every buffer from 0 up to 13 is filtered through one common mask. Buffer 14 and buffer 15 each have a private mask of their own. For each mask, a 1 bit means that identifier bit must agree with the buffer's programmed bit, and a 0 bit means that identifier bit is ignored.

Identifiers are 29 bits wide and left-aligned. A standard 11-bit identifier occupies bits 28:18, and bits 17:0 carry the extension. One global mask-type setting selects how the masks are read. In standard mode only bits 28:18 take part in the compare. In extended mode all 29 bits take part. A receive front end presents the identifier together with its IDE bit and a one-cycle strobe. One cycle later the filter produces a one-cycle result: a hit vector, a flag that is set when any buffer hit, and the index of the lowest-numbered hit.

Configuration uses two plain write ports. One port writes a buffer's identifier, type flag and enable. The other port writes a mask or the mask type.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `hit_valid`, `hit_vec`, `hit_any` and `hit_idx` are all zero. Every buffer is disabled, every mask is zero and the mask type is standard.
- R2: When `frame_stb` is high in a cycle, `hit_valid` is high for exactly the next cycle. In any cycle not preceded by a strobe, all result outputs are zero.
- R3: A mask bit of 1 requires the incoming identifier bit to equal the programmed bit. A mask bit of 0 makes that identifier bit don't-care.
- R4: Buffers 0 to 13 are all compared through the global mask, written with `msk_sel` = 0.
- R5: Buffer 14 uses the private mask written with `msk_sel` = 1. Buffer 15 uses the private mask written with `msk_sel` = 2.
- R6: A buffer can only hit when its type flag (1 = extended) equals the incoming `frame_ide`.
- R7: With the mask type set to standard (`msk_sel` = 3, `msk_val[0]` = 0), only identifier bits 28:18 are compared and bits 17:0 are ignored. With the mask type set to extended (`msk_val[0]` = 1), all 29 bits are compared.
- R8: A buffer whose enable bit is 0 never reports a hit.
- R9: `hit_idx` is the lowest index set in `hit_vec`. `hit_any` is the OR of `hit_vec`. When nothing hits, `hit_idx` is 0.
- R10: A configuration write takes effect from the following cycle. A strobe in the same cycle as a write is filtered with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Buffer configuration write enable |
| buf_addr | input | 4 | Buffer index to write |
| buf_id | input | 29 | Programmed identifier, left-aligned |
| buf_ext | input | 1 | Buffer frame type, 1 = extended |
| buf_en | input | 1 | Buffer enable |
| msk_we | input | 1 | Mask write enable |
| msk_sel | input | 2 | 0 global, 1 buffer 14, 2 buffer 15, 3 mask type |
| msk_val | input | 29 | Mask value; bit 0 is the mask type when `msk_sel` = 3 |
| frame_stb | input | 1 | Incoming identifier valid |
| frame_id | input | 29 | Incoming identifier, left-aligned |
| frame_ide | input | 1 | Incoming IDE bit |
| hit_valid | output | 1 | Result valid pulse |
| hit_vec | output | 16 | Per-buffer hit vector |
| hit_any | output | 1 | At least one buffer hit |
| hit_idx | output | 4 | Lowest-numbered hit |

## Verification
The filter is driven with exact-match identifiers and then with single-bit mismatches. It is tried once with the mismatching bit inside the standard field and once in the extension field, under each mask type. This separates the effect of the mask bits from the effect of the mask-type scope. Identical identifiers are programmed into a shared-mask buffer and into both private-mask buffers, with masks that differ. This shows which mask each buffer really uses, and it also produces several hits at once, which checks the lowest-index selection. Further cases cover opposite IDE values, buffers that are disabled, and strobes that arrive in the same cycle as a write. These are followed by a long stretch of random identifiers drawn close to the programmed ones.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int unsigned CF_NBUF = 16;
  localparam int unsigned CF_IDW  = 29;
  localparam int unsigned CF_STDW = 11;
  localparam int unsigned CF_EXTW = CF_IDW - CF_STDW;
  localparam int unsigned CF_IDXW = $clog2(CF_NBUF);
  localparam int unsigned CF_PRIV_A = CF_NBUF - 2;
  localparam int unsigned CF_PRIV_B = CF_NBUF - 1;

  typedef enum logic [1:0] {
    MSEL_GLOBAL = 2'd0,
    MSEL_PRIV_A = 2'd1,
    MSEL_PRIV_B = 2'd2,
    MSEL_TYPE   = 2'd3
  } msel_e;

  // Bits of the identifier that take part in the compare for a mask type.
  function automatic logic [CF_IDW-1:0] f_scope(input logic ext_mode);
    return ext_mode ? {CF_IDW{1'b1}} : {{CF_STDW{1'b1}}, {CF_EXTW{1'b0}}};
  endfunction

  // Identifier agreement under a mask restricted to a scope.
  function automatic logic f_id_match(input logic [CF_IDW-1:0] prog,
                                      input logic [CF_IDW-1:0] inc,
                                      input logic [CF_IDW-1:0] mask,
                                      input logic [CF_IDW-1:0] scope);
    return ((prog ^ inc) & mask & scope) == '0;
  endfunction

  // Index of the lowest set bit, zero for an empty vector.
  function automatic logic [CF_IDXW-1:0] f_lowest(input logic [CF_NBUF-1:0] v);
    logic [CF_IDXW-1:0] r;
    r = '0;
    for (int i = CF_NBUF - 1; i >= 0; i--) begin
      if (v[i]) r = CF_IDXW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/can_flt_cfg.sv
module can_flt_cfg
  import can_flt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    buf_we,
  input  logic [CF_IDXW-1:0]      buf_addr,
  input  logic [CF_IDW-1:0]       buf_id,
  input  logic                    buf_ext,
  input  logic                    buf_en,
  input  logic                    msk_we,
  input  logic [1:0]              msk_sel,
  input  logic [CF_IDW-1:0]       msk_val,
  output logic [CF_NBUF*CF_IDW-1:0] id_flat,
  output logic [CF_NBUF-1:0]      ext_vec,
  output logic [CF_NBUF-1:0]      en_vec,
  output logic [CF_IDW-1:0]       gmask,
  output logic [CF_IDW-1:0]       pmask_a,
  output logic [CF_IDW-1:0]       pmask_b,
  output logic                    ext_mode
);
  msel_e sel;
  assign sel = msel_e'(msk_sel);

  for (genvar b = 0; b < CF_NBUF; b++) begin : g_buf
    logic wr_here;
    assign wr_here = buf_we && (buf_addr == CF_IDXW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_flat[b*CF_IDW +: CF_IDW] <= '0;
        ext_vec[b]                  <= 1'b0;
        en_vec[b]                   <= 1'b0;
      end else if (wr_here) begin
        id_flat[b*CF_IDW +: CF_IDW] <= buf_id;
        ext_vec[b]                  <= buf_ext;
        en_vec[b]                   <= buf_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask    <= '0;
      pmask_a  <= '0;
      pmask_b  <= '0;
      ext_mode <= 1'b0;
    end else if (msk_we) begin
      case (sel)
        MSEL_GLOBAL: gmask    <= msk_val;
        MSEL_PRIV_A: pmask_a  <= msk_val;
        MSEL_PRIV_B: pmask_b  <= msk_val;
        MSEL_TYPE:   ext_mode <= msk_val[0];
        default:     ext_mode <= ext_mode;
      endcase
    end
  end
endmodule

// File: rtl/can_flt_cmp.sv
module can_flt_cmp
  import can_flt_pkg::*;
(
  input  logic [CF_NBUF*CF_IDW-1:0] id_flat,
  input  logic [CF_NBUF-1:0]      ext_vec,
  input  logic [CF_NBUF-1:0]      en_vec,
  input  logic [CF_IDW-1:0]       gmask,
  input  logic [CF_IDW-1:0]       pmask_a,
  input  logic [CF_IDW-1:0]       pmask_b,
  input  logic                    ext_mode,
  input  logic [CF_IDW-1:0]       frame_id,
  input  logic                    frame_ide,
  output logic [CF_NBUF-1:0]      hit_raw
);
  logic [CF_IDW-1:0] scope;
  assign scope = f_scope(ext_mode);

  for (genvar b = 0; b < CF_NBUF; b++) begin : g_cmp
    logic [CF_IDW-1:0] mask_b;
    if (b == CF_PRIV_A) begin : g_pa
      assign mask_b = pmask_a;
    end else if (b == CF_PRIV_B) begin : g_pb
      assign mask_b = pmask_b;
    end else begin : g_gl
      assign mask_b = gmask;
    end
    logic type_ok, id_ok;
    assign type_ok = (ext_vec[b] == frame_ide);
    assign id_ok   = f_id_match(id_flat[b*CF_IDW +: CF_IDW], frame_id, mask_b, scope);
    assign hit_raw[b] = en_vec[b] && type_ok && id_ok;
  end
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio
  import can_flt_pkg::*;
(
  input  logic [CF_NBUF-1:0] vec,
  output logic               any,
  output logic [CF_IDXW-1:0] idx
);
  assign any = |vec;
  assign idx = f_lowest(vec);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 buf_we,
  input  logic [CF_IDXW-1:0]   buf_addr,
  input  logic [CF_IDW-1:0]    buf_id,
  input  logic                 buf_ext,
  input  logic                 buf_en,
  input  logic                 msk_we,
  input  logic [1:0]           msk_sel,
  input  logic [CF_IDW-1:0]    msk_val,
  input  logic                 frame_stb,
  input  logic [CF_IDW-1:0]    frame_id,
  input  logic                 frame_ide,
  output logic                 hit_valid,
  output logic [CF_NBUF-1:0]   hit_vec,
  output logic                 hit_any,
  output logic [CF_IDXW-1:0]   hit_idx
);
  logic [CF_NBUF*CF_IDW-1:0] id_flat;
  logic [CF_NBUF-1:0]        ext_vec, en_vec, hit_raw, hit_gated;
  logic [CF_IDW-1:0]         gmask, pmask_a, pmask_b;
  logic                      ext_mode;
  logic                      any_c;
  logic [CF_IDXW-1:0]        idx_c;

  can_flt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_id(buf_id),
    .buf_ext(buf_ext), .buf_en(buf_en),
    .msk_we(msk_we), .msk_sel(msk_sel), .msk_val(msk_val),
    .id_flat(id_flat), .ext_vec(ext_vec), .en_vec(en_vec),
    .gmask(gmask), .pmask_a(pmask_a), .pmask_b(pmask_b), .ext_mode(ext_mode)
  );

  can_flt_cmp u_cmp (
    .id_flat(id_flat), .ext_vec(ext_vec), .en_vec(en_vec),
    .gmask(gmask), .pmask_a(pmask_a), .pmask_b(pmask_b), .ext_mode(ext_mode),
    .frame_id(frame_id), .frame_ide(frame_ide), .hit_raw(hit_raw)
  );

  assign hit_gated = frame_stb ? hit_raw : '0;

  can_flt_prio u_prio (.vec(hit_gated), .any(any_c), .idx(idx_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
      hit_any   <= 1'b0;
      hit_idx   <= '0;
    end else begin
      hit_valid <= frame_stb;
      hit_vec   <= hit_gated;
      hit_any   <= any_c;
      hit_idx   <= idx_c;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
  import can_flt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               frame_stb,
  input logic               hit_valid,
  input logic [CF_NBUF-1:0] hit_vec,
  input logic               hit_any,
  input logic [CF_IDXW-1:0] hit_idx,
  input logic [CF_NBUF-1:0] en_vec
);
  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> hit_valid); // R2
  AST_QUIET_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> (!hit_valid && hit_vec == '0 && !hit_any)); // R2
  AST_LOWEST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (hit_vec[hit_idx] &&
                 ((hit_vec & ((CF_NBUF'(1) << hit_idx) - CF_NBUF'(1))) == '0))); // R9
  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any == (hit_vec != '0)); // R9
  AST_IDX_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> hit_idx == '0); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ((hit_vec & ~$past(en_vec)) == '0)); // R8
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .hit_valid(hit_valid),
  .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx), .en_vec(en_vec)
);

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_we = 0, buf_ext = 0, buf_en = 0;
  logic [3:0]  buf_addr = 0;
  logic [28:0] buf_id = 0;
  logic        msk_we = 0;
  logic [1:0]  msk_sel = 0;
  logic [28:0] msk_val = 0;
  logic        frame_stb = 0, frame_ide = 0;
  logic [28:0] frame_id = 0;
  logic        hit_valid, hit_any;
  logic [15:0] hit_vec;
  logic [3:0]  hit_idx;

  int checks = 0, errors = 0;

  // reference state
  logic [28:0] m_id [16];
  logic        m_ext [16];
  logic        m_en [16];
  logic [28:0] m_gm = 0, m_pa = 0, m_pb = 0;
  logic        m_xt = 0;

  always #10 clk = ~clk;

  can_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr), .buf_id(buf_id),
    .buf_ext(buf_ext), .buf_en(buf_en), .msk_we(msk_we), .msk_sel(msk_sel),
    .msk_val(msk_val), .frame_stb(frame_stb), .frame_id(frame_id),
    .frame_ide(frame_ide), .hit_valid(hit_valid), .hit_vec(hit_vec),
    .hit_any(hit_any), .hit_idx(hit_idx)
  );

  function automatic bit ref_hit(int b, logic [28:0] fid, logic fide);
    logic [28:0] mk;
    int lo;
    if (!m_en[b]) return 0;
    if (m_ext[b] != fide) return 0;
    mk = (b == 14) ? m_pa : (b == 15) ? m_pb : m_gm;
    lo = m_xt ? 0 : 18;
    for (int k = lo; k < 29; k++)
      if (mk[k] && (fid[k] != m_id[b][k])) return 0;
    return 1;
  endfunction

  task automatic compare(string tag, logic ev, logic [15:0] evec, logic eany, logic [3:0] eidx);
    checks++;
    if (hit_valid !== ev || hit_vec !== evec || hit_any !== eany || hit_idx !== eidx) begin
      errors++;
      $display("FAIL %s: got v=%0b vec=%h any=%0b idx=%0d, expected v=%0b vec=%h any=%0b idx=%0d",
               tag, hit_valid, hit_vec, hit_any, hit_idx, ev, evec, eany, eidx);
    end
  endtask

  // One clock: expectation from the state before this cycle's writes.
  task automatic step(string tag);
    logic [15:0] ev;
    logic [3:0]  ei;
    ev = '0;
    ei = 0;
    if (frame_stb)
      for (int b = 0; b < 16; b++) ev[b] = ref_hit(b, frame_id, frame_ide);
    for (int b = 15; b >= 0; b--) if (ev[b]) ei = 4'(b);
    if (buf_we) begin
      m_id[buf_addr] = buf_id; m_ext[buf_addr] = buf_ext; m_en[buf_addr] = buf_en;
    end
    if (msk_we) begin
      case (msk_sel)
        2'd0: m_gm = msk_val;
        2'd1: m_pa = msk_val;
        2'd2: m_pb = msk_val;
        default: m_xt = msk_val[0];
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag, frame_stb, ev, ev != 0, ei);
    buf_we = 0; msk_we = 0; frame_stb = 0;
  endtask

  task automatic wbuf(int a, logic [28:0] id, logic ext, logic en);
    buf_we = 1; buf_addr = 4'(a); buf_id = id; buf_ext = ext; buf_en = en;
    step("R10");
  endtask

  task automatic wmsk(int s, logic [28:0] v);
    msk_we = 1; msk_sel = 2'(s); msk_val = v;
    step("R10");
  endtask

  task automatic probe(string tag, logic [28:0] id, logic ide);
    frame_stb = 1; frame_id = id; frame_ide = ide;
    step(tag);
    step("R2"); // idle cycle after the result
  endtask

  localparam logic [28:0] IDA = 29'h0ABC_1234;
  localparam logic [28:0] IDB = 29'h1555_0F0F;

  initial begin
    for (int b = 0; b < 16; b++) begin m_id[b] = 0; m_ext[b] = 0; m_en[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1", 0, 0, 0, 0);
    probe("R1", 29'h0, 1'b0);           // everything disabled after reset
    wmsk(0, '1);
    wbuf(3, IDA, 0, 1);
    probe("R4", IDA, 1'b0);
    probe("R6", IDA, 1'b1);
    probe("R3", IDA ^ 29'h0800_0000, 1'b0);
    wmsk(0, ~29'h0800_0000);
    probe("R3", IDA ^ 29'h0800_0000, 1'b0);
    probe("R7", IDA ^ 29'h0000_0020, 1'b0);  // extension bit ignored in standard
    wmsk(3, 29'h1);
    probe("R7", IDA ^ 29'h0000_0020, 1'b0);
    probe("R7", IDA, 1'b0);
    wbuf(14, IDA ^ 29'h0000_0020, 0, 1);
    wbuf(15, IDA ^ 29'h0000_0020, 0, 1);
    wmsk(1, 29'h0);
    wmsk(2, '1);
    probe("R5", IDA, 1'b0);             // 3 and 14 hit, 15 not
    probe("R5", IDA ^ 29'h0000_0020, 1'b0); // 14 and 15 hit
    wbuf(0, IDA, 0, 1);
    probe("R9", IDA, 1'b0);
    wbuf(0, IDA, 0, 0);
    wbuf(3, IDA, 0, 0);
    probe("R8", IDA, 1'b0);
    wbuf(7, IDB, 1, 1);
    probe("R6", IDB, 1'b1);
    probe("R6", IDB, 1'b0);
    // strobe in the same cycle as a write
    buf_we = 1; buf_addr = 7; buf_id = IDB; buf_ext = 1; buf_en = 0;
    frame_stb = 1; frame_id = IDB; frame_ide = 1;
    step("R10");
    probe("R10", IDB, 1'b1);
    msk_we = 1; msk_sel = 3; msk_val = 0;
    frame_stb = 1; frame_id = IDA; frame_ide = 0;
    step("R10");
    // random traffic near programmed identifiers
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        buf_we = 1; buf_addr = 4'($urandom_range(0, 15));
        buf_id = ($urandom_range(0, 1) != 0) ? IDA : IDB;
        buf_ext = 1'($urandom_range(0, 1)); buf_en = 1'($urandom_range(0, 3) != 0);
      end
      if ($urandom_range(0, 9) == 0) begin
        msk_we = 1; msk_sel = 2'($urandom_range(0, 3));
        msk_val = 29'($urandom) | 29'($urandom);
      end
      if ($urandom_range(0, 1) != 0) begin
        frame_stb = 1;
        frame_id = (($urandom_range(0, 1) != 0) ? IDA : IDB) ^ (29'd1 << $urandom_range(0, 28));
        if ($urandom_range(0, 3) == 0) frame_id = ($urandom_range(0, 1) != 0) ? IDA : IDB;
        frame_ide = 1'($urandom_range(0, 1));
      end
      step("R3");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule